// File: doc/BRIEF.md
# Double-Edge I/Q Input Capture with Strobe-Aligned Clock-Crossing FIFO

This block receives one or more 16-bit lanes that each carry a double-data-rate stream: an I word is sampled on the rising edge of the data clock and a Q word on the falling edge. Each lane's two words are joined into one I/Q pair. Every data-clock period, the pairs of all lanes are written together as one entry into an 8-entry FIFO, which is read out on the converter clock at one entry per cycle.

The FIFO pointers are not left to drift freely. A rising edge on the input strobe restarts the write pointer. The restart is then passed across to the read side, which places the read pointer four entries behind. In dual-sync mode the read pointer is instead placed by a separate output strobe sampled on the converter clock. Each lane can check a parity bit on every captured word. Lane 0 takes its parity from the strobe line when that line is switched to parity duty. Each word can be bit-reversed on entry. Sticky flags record parity errors and read/write pointer collisions until a clear pulse.

Top module: `ddr_iq_fifo_rx`

## Requirements
- R1: In lane l, the word sampled at a rising edge of `dclk` is the I word and the word sampled at the following falling edge is the Q word. The pair appears on `dout[l*32+31 : l*32+16]` (I) and `dout[l*32+15 : l*32]` (Q).
- R2: In steady operation, and from reset, the pair whose I word was sampled at rising edge n appears on `dout` after converter-clock edge n+6 (both clocks tied, write pointer four entries ahead of read pointer).
- R3: While `rev_bits` is 1 at capture, each 16-bit word is stored with its bit order reversed (bit 0 becomes bit 15).
- R4: On an enabled lane, a word whose parity bit differs from the XOR of its 16 data bits sets that lane's bit of `perr`. Lane 0 is enabled by `strb_par` and uses `strb` as its parity bit on both edges. Lane l≥1 is enabled by `par_aux_en[l-1]` and uses `par_aux[l-1]`. A bad rising-edge word shows after that edge; a bad falling-edge word shows after the next rising edge. A disabled lane never flags.
- R5: `alarm` and `perr` stay set until `flag_clr` is high at a clock edge. Clear wins over a new hit, and the flags read 0 after that edge.
- R6: With `strb_par`=0, a 0-to-1 change of `strb` seen at a rising `dclk` edge sets the write pointer to 0, once per rising edge, however long `strb` stays high. With `dual_sync`=0, the read pointer is then realigned three converter-clock edges later, so that the R2 latency returns.
- R7: With `strb_par`=1, transitions on `strb` never move the write pointer.
- R8: With `dual_sync`=1, a 0-to-1 change of `ostrb` seen at a `cclk` edge sets the read pointer to DEPTH/2. With `dual_sync`=0, `ostrb` has no effect.
- R9: `alarm` is set when the read pointer equals the write pointer as seen through the two-stage synchronizer. With tied clocks this happens when the write pointer leads by two entries, giving an output latency of four periods.
- R10: During reset, the write pointer is set to 0, the read pointer to DEPTH/2, and `dout`, `alarm` and `perr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock, both edges capture |
| cclk | input | 1 | Converter clock, FIFO read side |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| rev_bits | input | 1 | Reverse the bit order of each captured word |
| strb_par | input | 1 | Use `strb` as lane 0 parity instead of as a write-pointer strobe |
| dual_sync | input | 1 | Realign the read pointer from `ostrb` instead of from the write side |
| flag_clr | input | 1 | Clear sticky flags |
| din | input | LANES*16 | Lane data, lane l at bits [l*16 +: 16] |
| strb | input | 1 | Write-pointer strobe or lane 0 parity |
| par_aux | input | LANES-1 | Parity bits for lanes 1 and up |
| par_aux_en | input | LANES-1 | Parity check enables for lanes 1 and up |
| ostrb | input | 1 | Read-pointer strobe for dual-sync mode |
| dout | output | LANES*32 | FIFO output, one I/Q pair per lane |
| alarm | output | 1 | Sticky pointer-collision flag |
| perr | output | LANES | Sticky per-lane parity error flags |

## Verification
A table of words — all zeros, all ones, alternating bits, walking ones and mixed values, some entries reversed — shows that I and Q land in the right halves and that each word's bit order is kept or reversed as requested. Parity errors are placed on a rising-edge word, on a falling-edge word and on a disabled lane, which separates the two capture edges and the enable gating. The strobe tests hold `strb` high for many periods, toggle it in parity mode, and pulse `ostrb` in both modes. The output latency then shows whether a pointer moved once, not at all, or onto the collision distance that raises `alarm`.

// File: rtl/ddr_iqf_pkg.sv
package ddr_iqf_pkg;

    localparam int WORD_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0] i;
        logic [WORD_W-1:0] q;
    } iq_pair_t;

    localparam int PAIR_W = $bits(iq_pair_t);

    function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int j = 0; j < WORD_W; j++) r[j] = w[WORD_W-1-j];
        return r;
    endfunction

    function automatic logic parity_bad(input logic [WORD_W-1:0] w, input logic p);
        return (^w) ^ p;
    endfunction

endpackage

// File: rtl/ddr_lane_rx.sv
module ddr_lane_rx
    import ddr_iqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rev,
    input  logic [WORD_W-1:0] din,
    input  logic              par_in,
    input  logic              par_en,
    input  logic              flag_clr,
    output iq_pair_t          pair,
    output logic              perr
);

    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] i_hold;
    logic [WORD_W-1:0] q_fall;
    logic              q_bad;
    logic              rise_bad;

    assign word_in  = rev ? bit_rev(din) : din;
    assign rise_bad = par_en & parity_bad(din, par_in);

    // falling edge: Q word and its parity verdict
    always_ff @(negedge clk) begin
        if (rst) begin
            q_fall <= '0;
            q_bad  <= 1'b0;
        end else begin
            q_fall <= word_in;
            q_bad  <= par_en & parity_bad(din, par_in);
        end
    end

    // rising edge: I word, pair assembly, sticky parity flag
    always_ff @(posedge clk) begin
        if (rst) begin
            i_hold <= '0;
            pair   <= '0;
            perr   <= 1'b0;
        end else begin
            i_hold <= word_in;
            pair   <= '{i: i_hold, q: q_fall};
            if (flag_clr)
                perr <= 1'b0;
            else if (rise_bad || q_bad)
                perr <= 1'b1;
        end
    end

endmodule

// File: rtl/iq_sync_fifo.sv
module iq_sync_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 64
) (
    input  logic                     wclk,
    input  logic                     rclk,
    input  logic                     rst,
    input  logic [DW-1:0]            wdata,
    input  logic                     wsync,
    input  logic                     dual,
    input  logic                     ostrb,
    input  logic                     flag_clr,
    output logic [DW-1:0]            rdata,
    output logic                     alarm,
    output logic [$clog2(DEPTH)-1:0] wr_ptr,
    output logic [$clog2(DEPTH)-1:0] rd_ptr
);

    localparam int AW       = $clog2(DEPTH);
    localparam int SYNC_LAT = 3;                        // pulse flop + two stages
    localparam logic [AW-1:0] RD_RESET  = AW'(DEPTH - DEPTH/2);
    localparam logic [AW-1:0] RD_SINGLE = AW'(SYNC_LAT + DEPTH - DEPTH/2);
    localparam logic [AW-1:0] RD_DUAL   = AW'(DEPTH/2);

    function automatic logic [AW-1:0] gray2bin(input logic [AW-1:0] g);
        logic [AW-1:0] b;
        b[AW-1] = g[AW-1];
        for (int j = AW-2; j >= 0; j--) b[j] = b[j+1] ^ g[j];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wgray;
    logic [AW-1:0] wg_s1, wg_s2;
    logic          ws_pulse;
    logic          rs1, rs2;
    logic          ostrb_q;
    logic          rsync;
    logic [AW-1:0] rsync_val;
    logic [AW-1:0] wr_next;

    assign wr_next = wsync ? '0 : wr_ptr + 1'b1;

    // write domain
    always_ff @(posedge wclk) begin
        if (rst) begin
            wr_ptr   <= '0;
            wgray    <= '0;
            ws_pulse <= 1'b0;
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else begin
            mem[wr_ptr] <= wdata;
            wr_ptr      <= wr_next;
            wgray       <= wr_next ^ (wr_next >> 1);
            ws_pulse    <= wsync;
        end
    end

    // read-side realign source
    always_comb begin
        if (dual) begin
            rsync     = ostrb & ~ostrb_q;
            rsync_val = RD_DUAL;
        end else begin
            rsync     = rs2;
            rsync_val = RD_SINGLE;
        end
    end

    // read domain
    always_ff @(posedge rclk) begin
        if (rst) begin
            rd_ptr  <= RD_RESET;
            rdata   <= '0;
            wg_s1   <= '0;
            wg_s2   <= '0;
            rs1     <= 1'b0;
            rs2     <= 1'b0;
            ostrb_q <= 1'b0;
            alarm   <= 1'b0;
        end else begin
            wg_s1   <= wgray;
            wg_s2   <= wg_s1;
            rs1     <= ws_pulse;
            rs2     <= rs1;
            ostrb_q <= ostrb;
            rdata   <= mem[rd_ptr];
            rd_ptr  <= rsync ? rsync_val : rd_ptr + 1'b1;
            if (flag_clr)
                alarm <= 1'b0;
            else if (rd_ptr == gray2bin(wg_s2))
                alarm <= 1'b1;
        end
    end

endmodule

// File: rtl/ddr_iq_fifo_rx.sv
module ddr_iq_fifo_rx
    import ddr_iqf_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 8
) (
    input  logic                      dclk,
    input  logic                      cclk,
    input  logic                      rst,
    input  logic                      rev_bits,
    input  logic                      strb_par,
    input  logic                      dual_sync,
    input  logic                      flag_clr,
    input  logic [LANES*WORD_W-1:0]   din,
    input  logic                      strb,
    input  logic [LANES-2:0]          par_aux,
    input  logic [LANES-2:0]          par_aux_en,
    input  logic                      ostrb,
    output logic [LANES*PAIR_W-1:0]   dout,
    output logic                      alarm,
    output logic [LANES-1:0]          perr
);

    localparam int AW = $clog2(DEPTH);
    localparam int DW = LANES * PAIR_W;

    logic [DW-1:0] wdata;
    logic          strb_q;
    logic          wsync;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge dclk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb;
    end

    assign wsync = ~strb_par & strb & ~strb_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic     lane_par;
        logic     lane_en;
        iq_pair_t lane_pair;

        if (l == 0) begin : g_strb_par
            assign lane_par = strb;
            assign lane_en  = strb_par;
        end else begin : g_aux_par
            assign lane_par = par_aux[l-1];
            assign lane_en  = par_aux_en[l-1];
        end

        ddr_lane_rx u_rx (
            .clk      (dclk),
            .rst      (rst),
            .rev      (rev_bits),
            .din      (din[l*WORD_W +: WORD_W]),
            .par_in   (lane_par),
            .par_en   (lane_en),
            .flag_clr (flag_clr),
            .pair     (lane_pair),
            .perr     (perr[l])
        );

        assign wdata[l*PAIR_W +: PAIR_W] = lane_pair;
    end

    iq_sync_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .wclk     (dclk),
        .rclk     (cclk),
        .rst      (rst),
        .wdata    (wdata),
        .wsync    (wsync),
        .dual     (dual_sync),
        .ostrb    (ostrb),
        .flag_clr (flag_clr),
        .rdata    (dout),
        .alarm    (alarm),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr)
    );

endmodule

// File: rtl/ddr_iq_fifo_chk.sv
module ddr_iq_fifo_chk #(
    parameter int LANES = 2,
    parameter int DEPTH = 8,
    parameter int DW    = 64
) (
    input logic                     dclk,
    input logic                     cclk,
    input logic                     rst,
    input logic                     strb,
    input logic                     strb_par,
    input logic                     ostrb,
    input logic                     dual_sync,
    input logic                     flag_clr,
    input logic                     alarm,
    input logic [LANES-1:0]         perr,
    input logic [$clog2(DEPTH)-1:0] wr_ptr,
    input logic [$clog2(DEPTH)-1:0] rd_ptr,
    input logic [DW-1:0]            dout
);

    localparam int AW = $clog2(DEPTH);

    // R6
    wr_realign_chk: assert property (@(posedge dclk) disable iff (rst)
        (!strb_par && strb && !$past(strb) && !$past(rst)) |=> (wr_ptr == '0));

    // R7
    wr_advance_chk: assert property (@(posedge dclk) disable iff (rst)
        ((strb_par || !strb || $past(strb)) && !$past(rst))
            |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

    // R8
    rd_dual_align_chk: assert property (@(posedge cclk) disable iff (rst)
        (dual_sync && ostrb && !$past(ostrb) && !$past(rst))
            |=> (rd_ptr == AW'(DEPTH/2)));

    // R5
    alarm_clear_chk: assert property (@(posedge cclk) disable iff (rst)
        flag_clr |=> !alarm);

    // R5
    alarm_sticky_chk: assert property (@(posedge cclk) disable iff (rst)
        (alarm && !flag_clr) |=> alarm);

    // R5
    perr_clear_chk: assert property (@(posedge dclk) disable iff (rst)
        flag_clr |=> (perr == '0));

    // R5
    perr_sticky_chk: assert property (@(posedge dclk) disable iff (rst)
        (!flag_clr) |=> ((perr & $past(perr)) == $past(perr)));

    // R10
    rd_reset_chk: assert property (@(posedge cclk) disable iff (rst)
        $fell(rst) |-> (dout == '0 && !alarm && rd_ptr == AW'(DEPTH/2)));

    // R10
    wr_reset_chk: assert property (@(posedge dclk) disable iff (rst)
        $fell(rst) |-> (wr_ptr == '0));

endmodule

bind ddr_iq_fifo_rx ddr_iq_fifo_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH),
    .DW    (LANES * ddr_iqf_pkg::PAIR_W)
) u_chk (
    .dclk      (dclk),
    .cclk      (cclk),
    .rst       (rst),
    .strb      (strb),
    .strb_par  (strb_par),
    .ostrb     (ostrb),
    .dual_sync (dual_sync),
    .flag_clr  (flag_clr),
    .alarm     (alarm),
    .perr      (perr),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .dout      (dout)
);

// File: tb/ddr_iq_fifo_rx_tb.sv
module ddr_iq_fifo_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rev_bits = 1'b0;
    logic        strb_par = 1'b0;
    logic        dual_sync = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] din = '0;
    logic        strb = 1'b0;
    logic [0:0]  par_aux = '0;
    logic [0:0]  par_aux_en = 1'b1;
    logic        ostrb = 1'b0;
    logic [63:0] dout;
    logic        alarm;
    logic [1:0]  perr;

    always #10 clk = ~clk;

    ddr_iq_fifo_rx #(.LANES(2), .DEPTH(8)) u_dut (
        .dclk(clk), .cclk(clk), .rst(rst), .rev_bits(rev_bits),
        .strb_par(strb_par), .dual_sync(dual_sync), .flag_clr(flag_clr),
        .din(din), .strb(strb), .par_aux(par_aux), .par_aux_en(par_aux_en),
        .ostrb(ostrb), .dout(dout), .alarm(alarm), .perr(perr)
    );

    int checks = 0;
    int errors = 0;
    int k = 0;
    int wmod = 0;
    logic strb_prev = 1'b0;
    logic strb_lvl = 1'b0;
    logic bad_i0 = 0, bad_q0 = 0, bad_i1 = 0, bad_q1 = 0;
    logic [63:0] hist [256];
    logic [63:0] s_dout;
    logic        s_alarm;
    logic [1:0]  s_perr;

    // {rev, lane1 I, lane1 Q, lane0 I, lane0 Q}
    localparam logic [64:0] VEC [12] = '{
        {1'b0, 64'h0000_0000_0000_0000},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 64'hAAAA_5555_AAAA_5555},
        {1'b1, 64'h0001_8000_0003_C000},
        {1'b0, 64'h0001_0002_0004_0008},
        {1'b1, 64'h1234_5678_9ABC_DEF0},
        {1'b0, 64'hDEAD_BEEF_CAFE_F00D},
        {1'b1, 64'h00FF_FF00_0F0F_F0F0},
        {1'b0, 64'h8000_4000_2000_1000},
        {1'b0, 64'h5A5A_A5A5_3C3C_C3C3},
        {1'b1, 64'hFFFE_7FFF_0000_0001},
        {1'b0, 64'h1111_2222_3333_4444}
    };

    function automatic logic [63:0] revw(input logic [63:0] v);
        logic [63:0] r;
        for (int c = 0; c < 4; c++)
            for (int j = 0; j < 16; j++) r[c*16 + j] = v[c*16 + 15 - j];
        return r;
    endfunction

    function automatic logic [63:0] gen(input int n);
        return {16'(n * 947 + 4369), 16'((n * 711) ^ 23130),
                16'(n * 279 + 3855), 16'(~(n * 145))};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one data-clock period: I word on the rising edge, Q word on the falling edge
    task automatic step(input logic [63:0] v);
        din     = {v[63:48], v[31:16]};
        par_aux = (^v[63:48]) ^ bad_i1;
        strb    = strb_par ? ((^v[31:16]) ^ bad_i0) : strb_lvl;
        @(posedge clk);
        if (rst) wmod = 0;
        else if (!strb_par && strb && !strb_prev) wmod = 0;
        else wmod = (wmod + 1) % 8;
        strb_prev = rst ? 1'b0 : strb;
        hist[k % 256] = v;
        k++;
        #2;
        s_dout  = dout;
        s_alarm = alarm;
        s_perr  = perr;
        #3;
        din     = {v[47:32], v[15:0]};
        par_aux = (^v[47:32]) ^ bad_q1;
        if (strb_par) strb = (^v[15:0]) ^ bad_q0;
        @(negedge clk);
        #2;
    endtask

    function automatic logic [63:0] past(input int lat);
        return hist[(k - 1 - lat) % 256];
    endfunction

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] exp_tab [12];
        for (int i = 0; i < 3; i++) step(64'h0);
        rst = 1'b0;

        // R10: state after reset
        step(gen(1));
        chk("R10 dout", s_dout, 64'h0);
        chk("R10 alarm", {63'h0, s_alarm}, 64'h0);
        chk("R10 perr", {62'h0, s_perr}, 64'h0);
        for (int i = 0; i < 5; i++) step(gen(2 + i));

        // R1 R2 R3: table walk, output six periods later
        for (int i = 0; i < 18; i++) begin
            if (i < 12) begin
                rev_bits = VEC[i][64];
                exp_tab[i] = VEC[i][64] ? revw(VEC[i][63:0]) : VEC[i][63:0];
                step(VEC[i][63:0]);
            end else begin
                rev_bits = 1'b0;
                step(gen(20 + i));
            end
            if (i >= 6) chk("R1 R2 R3 table", s_dout, exp_tab[i-6]);
        end

        // R8: ostrb ignored while dual_sync is 0
        ostrb = 1'b1; step(gen(40)); step(gen(41)); ostrb = 1'b0;
        for (int i = 0; i < 6; i++) step(gen(42 + i));
        chk("R8 ostrb ignored", s_dout, past(6));

        // R4 R5: lane 1 rising-edge parity error, sticky, clear
        bad_i1 = 1; step(gen(50)); bad_i1 = 0;
        chk("R4 rise parity", {62'h0, s_perr}, 64'h2);
        step(gen(51)); step(gen(52));
        chk("R5 perr sticky", {62'h0, s_perr}, 64'h2);
        flag_clr = 1; step(gen(53)); flag_clr = 0;
        chk("R5 perr clear", {62'h0, s_perr}, 64'h0);

        // R4: falling-edge error appears one edge later
        bad_q1 = 1; step(gen(54)); bad_q1 = 0;
        chk("R4 fall parity not yet", {62'h0, s_perr}, 64'h0);
        step(gen(55));
        chk("R4 fall parity", {62'h0, s_perr}, 64'h2);
        flag_clr = 1; step(gen(56)); flag_clr = 0;

        // R4: disabled lane ignores bad parity
        par_aux_en = 1'b0; bad_i1 = 1; bad_q1 = 1;
        step(gen(57)); step(gen(58));
        bad_i1 = 0; bad_q1 = 0;
        step(gen(59));
        par_aux_en = 1'b1;
        chk("R4 disabled lane", {62'h0, s_perr}, 64'h0);

        // R4 R7: strobe line as lane 0 parity, pointers untouched
        strb_par = 1'b1;
        bad_q0 = 1; step(gen(60)); bad_q0 = 0;
        step(gen(61));
        chk("R4 lane0 parity via strobe", {62'h0, s_perr}, 64'h1);
        for (int i = 0; i < 8; i++) step(gen(62 + i));
        chk("R7 parity mode no realign", s_dout, past(6));
        flag_clr = 1; step(gen(70)); flag_clr = 0;
        strb_par = 1'b0; strb_lvl = 1'b0;
        step(gen(71));
        chk("R5 perr clear lane0", {62'h0, s_perr}, 64'h0);

        // R6: long strobe realigns once
        strb_lvl = 1'b1;
        for (int i = 0; i < 10; i++) step(gen(80 + i));
        chk("R6 held strobe single realign", s_dout, past(6));
        strb_lvl = 1'b0;
        for (int i = 0; i < 4; i++) step(gen(90 + i));
        flag_clr = 1; step(gen(94)); flag_clr = 0;
        step(gen(95));
        chk("R5 alarm cleared", {63'h0, s_alarm}, 64'h0);

        // R8 R9: dual-sync read realign onto the collision distance
        dual_sync = 1'b1;
        while (wmod != 5) step(gen(100 + k % 7));
        ostrb = 1'b1; step(gen(110));
        chk("R9 no alarm at realign edge", {63'h0, s_alarm}, 64'h0);
        step(gen(111));
        chk("R9 collision alarm", {63'h0, s_alarm}, 64'h1);
        ostrb = 1'b0;
        for (int i = 0; i < 5; i++) step(gen(112 + i));
        chk("R8 dual realign latency", s_dout, past(4));
        chk("R5 alarm sticky", {63'h0, s_alarm}, 64'h1);

        // R6: single-mode strobe restores latency via the read side
        dual_sync = 1'b0;
        strb_lvl = 1'b1; step(gen(120)); step(gen(121)); strb_lvl = 1'b0;
        for (int i = 0; i < 8; i++) step(gen(122 + i));
        chk("R6 read realign", s_dout, past(6));
        flag_clr = 1; step(gen(130)); flag_clr = 0;
        chk("R5 alarm clear", {63'h0, s_alarm}, 64'h0);
        step(gen(131)); step(gen(132));
        chk("R9 no alarm at distance four", {63'h0, s_alarm}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule